// File: doc/BRIEF.md
# Multiplexed Cartridge Bus Target

This block is the device end of a 16-bit multiplexed address/data bus. The host puts the upper half of a 32-bit byte address on the shared lines and drops the high latch strobe, then puts the lower half on the same lines and drops the low latch strobe. After that, every read strobe pulse returns one 16-bit word and every write strobe pulse stores one word. After each pulse the block advances its internal byte address by two, so a burst walks through consecutive words without the address being sent again.

The block answers only inside a window of `MEM_WORDS` words that starts at byte address `BASE_ADDR`. Reads inside the window drive the stored word and raise the drive enable. Writes inside the window update the word store, which is a register array. Outside the window the block keeps stepping its address but stays silent. Raising the high latch strobe ends the transaction, and the block then waits for a fresh address. All strobes and the shared lines are brought into the device clock through a two-stage synchronizer, and edges are detected on the synchronized levels.

Top module: `cart_bus_target`

## Requirements
- R1: While reset is held and straight after it, the drive enable is 0 and the read data output is 0.
- R2: A falling edge on the high latch strobe takes the shared lines as address bits 31:16. A different upper half moves the address out of the window, and the block then does not drive.
- R3: A falling edge on the low latch strobe, after the high one has fallen, takes the shared lines as address bits 15:0. While the read strobe is then low, the block drives the word stored at that address with the drive enable at 1.
- R4: Each rising edge of the read strobe advances the internal byte address by 2, so the next read pulse returns the following word.
- R5: On each rising edge of the write strobe inside the window, the value on the shared lines is stored at the current address, and the address then advances by 2.
- R6: While the write strobe is low the drive enable stays 0, and the shared lines are left to the host.
- R7: The block drives only when the current address lies in [BASE_ADDR, BASE_ADDR + 2*MEM_WORDS). Writes outside that range change no stored word. A burst that starts below the window begins to drive once its address reaches the window.
- R8: A rising edge on the high latch strobe returns the block to idle. Read pulses in idle are not answered. A low latch strobe falling without a preceding high latch fall is ignored.
- R9: A burst that runs past the last word of the window stops driving on the first read pulse beyond it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad_i | input | 16 | Shared address/data lines as seen by the device |
| latch_hi_n_i | input | 1 | High address latch strobe, active low |
| latch_lo_n_i | input | 1 | Low address latch strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| bus_ad_o | output | 16 | Read data driven toward the shared lines |
| bus_oe_o | output | 1 | Drive enable for bus_ad_o |

## Verification
The bench fills the whole window in one burst and reads it back in one burst. It then starts a two-word read at every word offset, so any slip of the address step, or a counter that does not advance, shows up as wrong data on a neighbour word. Bursts that cross the top and the bottom edge of the window catch a window compare that is off by one or that wraps. A write beyond the window is followed by a read of word 0; a design that drops the range check aliases that write onto word 0. The remaining checks cover a latch with the wrong upper half, a low latch with no high latch, and read pulses after release. These catch a block that leaves its address live after release, or that drives during writes.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    // Strobe lane order inside the synchronizer vector
    localparam int STB_HI = 0;
    localparam int STB_LO = 1;
    localparam int STB_RD = 2;
    localparam int STB_WR = 3;
    localparam int STB_N  = 4;

    typedef enum logic [1:0] {
        LINK_IDLE   = 2'd0,
        LINK_HIGH   = 2'd1,
        LINK_ACTIVE = 2'd2
    } link_e;

endpackage

// File: rtl/cbt_strobe_sync.sv
module cbt_strobe_sync
    import cbt_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STB_N-1:0]  strobe_n_i,
    input  logic [DW-1:0]     ad_i,
    output logic [STB_N-1:0]  level_n_o,
    output logic [STB_N-1:0]  fall_o,
    output logic [STB_N-1:0]  rise_o,
    output logic [DW-1:0]     ad_o
);

    logic [STB_N-1:0] prev_d, prev_q;

    // one synchronizer chain per strobe, idling high
    for (genvar g = 0; g < STB_N; g++) begin : g_lane
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], strobe_n_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign level_n_o[g] = chain_q[STAGES-1];
        assign fall_o[g]    = prev_q[g] & ~chain_q[STAGES-1];
        assign rise_o[g]    = ~prev_q[g] & chain_q[STAGES-1];
    end

    always_comb begin
        prev_d = level_n_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    // data lines delayed by the same depth so they line up with the edges
    logic [DW-1:0] pipe_d [STAGES];
    logic [DW-1:0] pipe_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_pipe
        if (s == 0) begin : g_first
            always_comb pipe_d[s] = ad_i;
        end else begin : g_next
            always_comb pipe_d[s] = pipe_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[s] <= '0;
            else        pipe_q[s] <= pipe_d[s];
        end
    end

    assign ad_o = pipe_q[STAGES-1];

endmodule

// File: rtl/cbt_word_store.sv
module cbt_word_store #(
    parameter int WORDS = 256,
    parameter int DW    = 16,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] cell_d [WORDS];
    logic [DW-1:0] cell_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_cell
        always_comb begin
            cell_d[w] = cell_q[w];
            if (we_i && (idx_i == IW'(w))) cell_d[w] = wdata_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q[w] <= '0;
            else        cell_q[w] <= cell_d[w];
        end
    end

    assign rdata_o = cell_q[idx_i];

endmodule

// File: rtl/cart_bus_target.sv
module cart_bus_target
    import cbt_pkg::*;
#(
    parameter int          MEM_WORDS = 256,
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_ad_i,
    input  logic        latch_hi_n_i,
    input  logic        latch_lo_n_i,
    input  logic        rd_n_i,
    input  logic        wr_n_i,
    output logic [15:0] bus_ad_o,
    output logic        bus_oe_o
);

    localparam int          DW        = 16;
    localparam int          IW        = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;
    localparam logic [31:0] WIN_BYTES = 32'(MEM_WORDS * 2);
    localparam logic [31:0] STEP      = 32'd2;

    typedef struct packed {
        link_e         link;
        logic [31:0]   addr;
        logic          oe;
        logic [DW-1:0] dout;
    } state_t;

    state_t st_d, st_q;

    logic [STB_N-1:0] level_n, fall, rise;
    logic [DW-1:0]    ad_sync;
    logic [31:0]      offset;
    logic             in_win;
    logic [IW-1:0]    word_idx;
    logic             store_we;
    logic [DW-1:0]    store_rdata;

    cbt_strobe_sync #(
        .STAGES (SYNC_STAGES),
        .DW     (DW)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i ({wr_n_i, rd_n_i, latch_lo_n_i, latch_hi_n_i}),
        .ad_i       (bus_ad_i),
        .level_n_o  (level_n),
        .fall_o     (fall),
        .rise_o     (rise),
        .ad_o       (ad_sync)
    );

    cbt_word_store #(
        .WORDS (MEM_WORDS),
        .DW    (DW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (store_we),
        .idx_i   (word_idx),
        .wdata_i (ad_sync),
        .rdata_o (store_rdata)
    );

    // window decode: below-base addresses wrap to a large offset
    assign offset   = st_q.addr - BASE_ADDR;
    assign in_win   = offset < WIN_BYTES;
    assign word_idx = offset[IW:1];

    always_comb begin
        st_d     = st_q;
        store_we = 1'b0;

        if (rise[STB_HI]) begin
            st_d.link = LINK_IDLE;
            st_d.addr = '0;
        end else begin
            if (fall[STB_HI]) begin
                st_d.addr[31:16] = ad_sync;
                st_d.link        = LINK_HIGH;
            end
            if (fall[STB_LO] && st_q.link == LINK_HIGH) begin
                st_d.addr[15:0] = ad_sync;
                st_d.link       = LINK_ACTIVE;
            end
            if (st_q.link == LINK_ACTIVE) begin
                if (rise[STB_WR]) store_we = in_win;
                if (rise[STB_RD] || rise[STB_WR]) st_d.addr = st_q.addr + STEP;
            end
        end

        st_d.oe   = (st_q.link == LINK_ACTIVE) && in_win &&
                    !level_n[STB_RD] && level_n[STB_WR];
        st_d.dout = st_d.oe ? store_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.link <= LINK_IDLE;
            st_q.addr <= '0;
            st_q.oe   <= 1'b0;
            st_q.dout <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_ad_o = st_q.dout;
    assign bus_oe_o = st_q.oe;

endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
    import cbt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
    parameter logic [31:0] WIN_BYTES = 32'd512
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_n_i,
    input logic        rd_rise,
    input logic        hi_rise,
    input link_e       link,
    input logic [31:0] addr,
    input logic [15:0] dout,
    input logic        oe
);

    logic [2:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 7) age_q <= age_q + 3'd1;
    end

    // R1: quiet outputs during reset
    always @(negedge clk) begin
        if (!rst_n) begin
            p_quiet_in_reset_r1: assert (!oe && dout == '0);
        end
    end

    // R6: a write strobe held low keeps the drive enable off
    p_silent_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 7 && !wr_n_i && !$past(wr_n_i) && !$past(wr_n_i, 2) &&
         !$past(wr_n_i, 3)) |-> !oe);

    // R7: driving implies an active link and an in-window address
    p_drive_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 0 && oe) |->
        ($past(link) == LINK_ACTIVE && ($past(addr) - BASE_ADDR) < WIN_BYTES));

    // R4: a read strobe release advances the byte address by two
    p_step_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && !hi_rise && link == LINK_ACTIVE) |=>
        (addr == $past(addr) + 32'd2));

    // R8: high latch release returns to idle
    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rise |=> (link == LINK_IDLE));

endmodule

bind cart_bus_target cbt_checker #(
    .BASE_ADDR (BASE_ADDR),
    .WIN_BYTES (WIN_BYTES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n_i  (wr_n_i),
    .rd_rise (rise[cbt_pkg::STB_RD]),
    .hi_rise (rise[cbt_pkg::STB_HI]),
    .link    (st_q.link),
    .addr    (st_q.addr),
    .dout    (bus_ad_o),
    .oe      (bus_oe_o)
);

// File: tb/test_cart_bus_target.sv
module test_cart_bus_target;

    localparam int          WORDS = 16;
    localparam logic [31:0] BASE  = 32'h0800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ad = '0;
    logic        hi_n = 1'b1, lo_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] dout;
    logic        oe;

    int chk_n = 0;
    int bad_n = 0;
    bit done  = 1'b0;
    logic [15:0] model [WORDS];

    always #2 clk = ~clk;

    cart_bus_target #(
        .MEM_WORDS (WORDS),
        .BASE_ADDR (BASE)
    ) i_cart_bus_target (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_ad_i     (ad),
        .latch_hi_n_i (hi_n),
        .latch_lo_n_i (lo_n),
        .rd_n_i       (rd_n),
        .wr_n_i       (wr_n),
        .bus_ad_o     (dout),
        .bus_oe_o     (oe)
    );

    function automatic logic [15:0] pat(input int i);
        return 16'h5A00 + 16'(i) * 16'h0103;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk_n++;
        if (act !== exp) begin
            bad_n++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_addr(input logic [31:0] a);
        ad = a[31:16]; wait_n(3);
        hi_n = 1'b0;   wait_n(4);
        ad = a[15:0];  wait_n(3);
        lo_n = 1'b0;   wait_n(4);
    endtask

    task automatic close_addr();
        lo_n = 1'b1; hi_n = 1'b1; wait_n(5);
    endtask

    task automatic rd_pulse(output logic oe_s, output logic [15:0] d_s);
        rd_n = 1'b0; wait_n(6);
        oe_s = oe; d_s = dout;
        rd_n = 1'b1; wait_n(4);
    endtask

    task automatic wr_pulse(input logic [15:0] d, output logic oe_s);
        ad = d; wait_n(3);
        wr_n = 1'b0; wait_n(5);
        oe_s = oe;
        wr_n = 1'b1; wait_n(4);
    endtask

    // read one word and compare against the model (or silence)
    task automatic expect_read(input string req, input bit live, input logic [15:0] exp);
        logic o; logic [15:0] d;
        rd_pulse(o, d);
        check(req, {31'd0, o}, {31'd0, live});
        if (live) check(req, {16'd0, d}, {16'd0, exp});
    endtask

    initial begin
        logic o;
        logic [15:0] d;
        for (int i = 0; i < WORDS; i++) model[i] = '0;

        wait_n(3);
        check("R1 oe in reset", {31'd0, oe}, 32'd0);
        check("R1 data in reset", {16'd0, dout}, 32'd0);
        rst_n = 1'b1;
        wait_n(3);
        check("R1 oe after reset", {31'd0, oe}, 32'd0);

        // R5 / R6: fill the whole window in one burst
        open_addr(BASE);
        for (int i = 0; i < WORDS; i++) begin
            wr_pulse(pat(i), o);
            model[i] = pat(i);
            check("R6 no drive while writing", {31'd0, o}, 32'd0);
        end
        close_addr();

        // R3 / R4: read it back in one burst, then R9 past the end
        open_addr(BASE);
        for (int i = 0; i < WORDS; i++) expect_read("R3 R4 burst read", 1'b1, model[i]);
        expect_read("R9 past window end", 1'b0, '0);
        close_addr();

        // R4 / R9: two-word bursts from every offset
        for (int s = 0; s < WORDS; s++) begin
            open_addr(BASE + 32'(2 * s));
            for (int j = 0; j < 2; j++) begin
                if (s + j < WORDS) expect_read("R4 offset burst", 1'b1, model[s + j]);
                else               expect_read("R9 offset burst end", 1'b0, '0);
            end
            close_addr();
        end

        // R7: start below the window, walk into it
        open_addr(BASE - 32'd2);
        expect_read("R7 below window", 1'b0, '0);
        expect_read("R7 walked into window", 1'b1, model[0]);
        close_addr();

        // R7: write just beyond the window must not alias onto word 0
        open_addr(BASE + 32'(2 * WORDS));
        wr_pulse(16'hDEAD, o);
        check("R7 no drive outside", {31'd0, o}, 32'd0);
        close_addr();
        open_addr(BASE);
        expect_read("R7 word0 untouched", 1'b1, model[0]);
        close_addr();

        // R2: wrong upper half leaves the window
        open_addr({BASE[31:16] ^ 16'h0100, BASE[15:0]});
        expect_read("R2 upper half decoded", 1'b0, '0);
        close_addr();

        // R5: overwrite a middle word, keep reading in the same burst
        open_addr(BASE + 32'd10);
        wr_pulse(16'h1234, o);
        model[5] = 16'h1234;
        expect_read("R5 advance after write", 1'b1, model[6]);
        close_addr();
        open_addr(BASE + 32'd10);
        expect_read("R5 stored word", 1'b1, model[5]);
        close_addr();

        // R8: idle after release, and a low latch alone is ignored
        expect_read("R8 idle after release", 1'b0, '0);
        ad = BASE[15:0]; wait_n(3);
        lo_n = 1'b0; wait_n(4);
        expect_read("R8 low latch alone", 1'b0, '0);
        lo_n = 1'b1; wait_n(4);
        open_addr(BASE + 32'd4);
        expect_read("R8 reopen after idle", 1'b1, model[2]);
        close_addr();

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_n, bad_n);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk_n++;
            bad_n++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_n, bad_n);
            $finish;
        end
    end

endmodule